// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the beam timing of a tile-based video display processor. It runs on an internal dot clock and counts a fixed number of cycles per line and a standard-dependent number of lines per frame. The current column and row are brought out, together with one-hot strobes that divide every cycle into border, blanking, sync, colour burst or active pixel. A vertical-sync line flag, a per-line refresh flag and a sticky frame-interrupt flag are also brought out.

The frame geometry is fixed once per frame, at a single latch point early in row 0. This geometry is the line total (50 Hz or 60 Hz standard), the number of active pixel lines and the first vertical-sync row. In the extended tile mode, the active line count comes from three mode bits and the sync row is derived from it. Text mode and display blanking are taken at the start of each line. Pixel fetch, sprites, palette and analogue output belong to other blocks that consume these strobes.

Top module: `video_raster_timer`

## Requirements
- R1: After reset, column and row are 0. The column counts 0 to LINE_CYCLES-1 (default 342 cycles) and then wraps to 0. At that wrap the row advances by one.
- R2: On lines outside vertical sync, each line has a fixed layout. Columns 0-14 are border. Columns 15-22 are blank, 23-48 are sync, 49-50 are blank, 51-64 are colour burst and 65-72 are blank. Columns from 73 up to the pixel start are border. Exactly one of border_o, blank_o, sync_o, burst_o, pixel_o is high in every cycle.
- R3: On a pixel line, pixels cover columns 86-341 in standard mode. In text mode they cover columns 94-333, and columns 86-93 and 334-341 are border.
- R4: A line carries pixels only when refresh_o is low and its row is below the latched active line count. Otherwise its pixel span is border.
- R5: Rows from the first vertical-sync row up to three rows beyond it have vsync_o high and sync_o high for the whole line.
- R6: The latched standard selects the frame length. With pal_sel=0 a frame has NTSC_LINES rows (default 262). With pal_sel=1 it has PAL_LINES rows (default 313). Outside the extended mode, the first sync row is NTSC_VS (227) or PAL_VS (253).
- R7: With ext_mode=1, the active line count is chosen from mode_sel, where bit 0 is mode 1, bit 1 is mode 2 and bit 2 is mode 3. Bits 1 and 2 both set select ACT_TALL (240). Otherwise bits 1 and 0 both set select ACT_MID (224). Any other value selects ACT_BASE (192). With ext_mode=0 the count is ACT_BASE.
- R8: With ext_mode=1, the first sync row is (frame rows + active lines) / 2, rounded down.
- R9: pal_sel, ext_mode and mode_sel are sampled only on the edge where row 0, column LATCH_COL (61) ends. Changes at any other time have no effect on the current frame.
- R10: frame_irq_o rises in the cycle after the beam leaves column IRQ_COL on row (active lines + 1). It stays high until irq_clr is seen on an edge. A set and a clear on the same edge leave it high.
- R11: text_mode and blank_disp are sampled on the last cycle of a line and govern the next line. refresh_o is high on a line whose start saw blank_disp, or whose row is at or beyond the active count. It is low on the frame's last row unless blanking was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_sel | input | 1 | 1 selects the 50 Hz frame length, 0 the 60 Hz one |
| ext_mode | input | 1 | Enables the extended tile mode geometry |
| mode_sel | input | 3 | Mode bits 1, 2, 3 in bits 0, 1, 2 |
| text_mode | input | 1 | Narrow text-mode pixel window for the next line |
| blank_disp | input | 1 | Blanks the display from the next line on |
| irq_clr | input | 1 | Clears the frame interrupt flag |
| col_o | output | COL_W (9) | Current column |
| row_o | output | ROW_W (9) | Current row |
| sync_o | output | 1 | Sync strobe |
| blank_o | output | 1 | Blanking strobe |
| burst_o | output | 1 | Colour-burst strobe |
| border_o | output | 1 | Border strobe |
| pixel_o | output | 1 | Active pixel strobe |
| vsync_o | output | 1 | Current row is a vertical-sync row |
| refresh_o | output | 1 | Current line is a refresh / border-only line |
| frame_irq_o | output | 1 | Sticky frame interrupt flag |

## Verification
A column counter that slips by one cycle moves every strobe edge, so the next line's border-to-blank transition shows the error within 342 cycles. A wrong latched geometry shows up later. A pixel line may turn into a border line, or the reverse, near the active boundary. The sync rows and the interrupt row then move, and the frame wrap lands on the wrong row, so the error appears well within one frame. A flag that drops on its own, or a parameter sampled mid-frame, shows up only on the next row that depends on it. For that reason the scenarios change inputs well away from the latch point and look again many rows later.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [2:0] {
        RG_BORDER = 3'd0,
        RG_BLANK  = 3'd1,
        RG_SYNC   = 3'd2,
        RG_BURST  = 3'd3,
        RG_PIXEL  = 3'd4
    } region_t;
endpackage

// File: rtl/raster_geom.sv
module raster_geom #(
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 313,
    parameter int NTSC_VS    = 227,
    parameter int PAL_VS     = 253,
    parameter int ACT_BASE   = 192,
    parameter int ACT_MID    = 224,
    parameter int ACT_TALL   = 240,
    parameter int ROW_W      = 9
) (
    input  logic             pal,
    input  logic             ext,
    input  logic [2:0]       mode_bits,
    output logic [ROW_W-1:0] total,
    output logic [ROW_W-1:0] active,
    output logic [ROW_W-1:0] vs_first
);
    logic [ROW_W:0] sum;

    always_comb begin
        total  = pal ? ROW_W'(PAL_LINES) : ROW_W'(NTSC_LINES);
        active = ROW_W'(ACT_BASE);
        if (ext) begin
            // mode 2 + mode 3 outranks mode 2 + mode 1
            if (mode_bits[1] && mode_bits[0]) active = ROW_W'(ACT_MID);
            if (mode_bits[1] && mode_bits[2]) active = ROW_W'(ACT_TALL);
        end
        sum = {1'b0, total} + {1'b0, active};
        if (ext) vs_first = sum[ROW_W:1];
        else     vs_first = pal ? ROW_W'(PAL_VS) : ROW_W'(NTSC_VS);
    end
endmodule

// File: rtl/raster_hdecode.sv
module raster_hdecode
    import raster_pkg::*;
#(
    parameter int LINE_CYCLES = 342,
    parameter int COL_W       = 9,
    parameter int BORDER_R    = 15,
    parameter int BLANK_A     = 8,
    parameter int SYNC_LEN    = 26,
    parameter int BLANK_B     = 2,
    parameter int BURST_LEN   = 14,
    parameter int BLANK_C     = 8,
    parameter int PIX_START   = 86,
    parameter int TEXT_START  = 94,
    parameter int TEXT_END    = 334
) (
    input  logic [COL_W-1:0] col,
    input  logic             text,
    input  logic             show_pix,
    input  logic             vsync_line,
    output region_t          region
);
    localparam int SYNC_S  = BORDER_R + BLANK_A;
    localparam int SYNC_E  = SYNC_S + SYNC_LEN;
    localparam int BURST_S = SYNC_E + BLANK_B;
    localparam int BURST_E = BURST_S + BURST_LEN;
    localparam int BLANK_E = BURST_E + BLANK_C;

    logic [COL_W:0] pix_s, pix_e;
    logic [COL_W:0] c;

    always_comb begin
        c     = {1'b0, col};
        pix_s = text ? (COL_W+1)'(TEXT_START) : (COL_W+1)'(PIX_START);
        pix_e = text ? (COL_W+1)'(TEXT_END)   : (COL_W+1)'(LINE_CYCLES);
        if (vsync_line)                         region = RG_SYNC;
        else if (c < (COL_W+1)'(BORDER_R))      region = RG_BORDER;
        else if (c < (COL_W+1)'(SYNC_S))        region = RG_BLANK;
        else if (c < (COL_W+1)'(SYNC_E))        region = RG_SYNC;
        else if (c < (COL_W+1)'(BURST_S))       region = RG_BLANK;
        else if (c < (COL_W+1)'(BURST_E))       region = RG_BURST;
        else if (c < (COL_W+1)'(BLANK_E))       region = RG_BLANK;
        else if (c < pix_s)                     region = RG_BORDER;
        else if (c < pix_e && show_pix)         region = RG_PIXEL;
        else                                    region = RG_BORDER;
    end
endmodule

// File: rtl/video_raster_timer.sv
module video_raster_timer
    import raster_pkg::*;
#(
    parameter int LINE_CYCLES = 342,
    parameter int NTSC_LINES  = 262,
    parameter int PAL_LINES   = 313,
    parameter int NTSC_VS     = 227,
    parameter int PAL_VS      = 253,
    parameter int VS_LINES    = 4,
    parameter int ACT_BASE    = 192,
    parameter int ACT_MID     = 224,
    parameter int ACT_TALL    = 240,
    parameter int LATCH_COL   = 61,
    parameter int IRQ_COL     = 30,
    localparam int MAX_LINES  = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
    localparam int COL_W      = $clog2(LINE_CYCLES),
    localparam int ROW_W      = $clog2(MAX_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_sel,
    input  logic             ext_mode,
    input  logic [2:0]       mode_sel,
    input  logic             text_mode,
    input  logic             blank_disp,
    input  logic             irq_clr,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o,
    output logic             sync_o,
    output logic             blank_o,
    output logic             burst_o,
    output logic             border_o,
    output logic             pixel_o,
    output logic             vsync_o,
    output logic             refresh_o,
    output logic             frame_irq_o
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_CYCLES - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] total;
        logic [ROW_W-1:0] active;
        logic [ROW_W-1:0] vs_first;
        logic             text;
        logic             refresh;
        logic             irq;
    } tstate_t;

    tstate_t s_q, s_d;

    logic [ROW_W-1:0] g_total, g_active, g_vs;
    logic [ROW_W-1:0] nrow, last_row;
    logic             at_latch, line_end, irq_hit, vsync_line, show_pix;
    region_t          region;

    raster_geom #(
        .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
        .NTSC_VS(NTSC_VS), .PAL_VS(PAL_VS),
        .ACT_BASE(ACT_BASE), .ACT_MID(ACT_MID), .ACT_TALL(ACT_TALL),
        .ROW_W(ROW_W)
    ) u_geom (
        .pal(pal_sel), .ext(ext_mode), .mode_bits(mode_sel),
        .total(g_total), .active(g_active), .vs_first(g_vs)
    );

    raster_hdecode #(
        .LINE_CYCLES(LINE_CYCLES), .COL_W(COL_W)
    ) u_hdec (
        .col(s_q.col), .text(s_q.text), .show_pix(show_pix),
        .vsync_line(vsync_line), .region(region)
    );

    always_comb begin
        last_row   = s_q.total - ROW_W'(1);
        at_latch   = (s_q.row == '0) && (s_q.col == COL_W'(LATCH_COL));
        line_end   = (s_q.col == LAST_COL);
        nrow       = (s_q.row == last_row) ? '0 : s_q.row + ROW_W'(1);
        irq_hit    = ({1'b0, s_q.row} == ({1'b0, s_q.active} + (ROW_W+1)'(1)))
                     && (s_q.col == COL_W'(IRQ_COL));
        vsync_line = ({1'b0, s_q.row} >= {1'b0, s_q.vs_first})
                     && ({1'b0, s_q.row} < ({1'b0, s_q.vs_first} + (ROW_W+1)'(VS_LINES)));
        show_pix   = !s_q.refresh && (s_q.row < s_q.active);
    end

    always_comb begin
        s_d = s_q;
        if (at_latch) begin
            s_d.total    = g_total;
            s_d.active   = g_active;
            s_d.vs_first = g_vs;
        end
        if (line_end) begin
            s_d.col     = '0;
            s_d.row     = nrow;
            s_d.text    = text_mode;
            s_d.refresh = blank_disp || ((nrow >= s_q.active) && (nrow != last_row));
        end else begin
            s_d.col = s_q.col + COL_W'(1);
        end
        if (irq_hit)      s_d.irq = 1'b1;
        else if (irq_clr) s_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.col      <= '0;
            s_q.row      <= '0;
            s_q.total    <= ROW_W'(NTSC_LINES);
            s_q.active   <= ROW_W'(ACT_BASE);
            s_q.vs_first <= ROW_W'(NTSC_VS);
            s_q.text     <= 1'b0;
            s_q.refresh  <= 1'b0;
            s_q.irq      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign col_o       = s_q.col;
    assign row_o       = s_q.row;
    assign sync_o      = (region == RG_SYNC);
    assign blank_o     = (region == RG_BLANK);
    assign burst_o     = (region == RG_BURST);
    assign border_o    = (region == RG_BORDER);
    assign pixel_o     = (region == RG_PIXEL);
    assign vsync_o     = vsync_line;
    assign refresh_o   = s_q.refresh;
    assign frame_irq_o = s_q.irq;

    // R1: column wraps after the last cycle of a line
    a_r1_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.col == LAST_COL) |=> (s_q.col == '0));
    // R1: column steps by one elsewhere
    a_r1_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.col != LAST_COL) |=> (s_q.col == $past(s_q.col) + COL_W'(1)));
    // R6: row stays inside the latched frame length
    a_r6_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.row < s_q.total);
    // R9: geometry moves only at the latch point
    a_r9_geom_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !at_latch |=> ($stable(s_q.active) && $stable(s_q.total) && $stable(s_q.vs_first)));
    // R10: the flag holds until cleared
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !irq_clr) |=> s_q.irq);
    // R5: a vertical-sync row drives sync all line long
    a_r5_vsync_sync: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o |-> sync_o);
    // R4: pixels only on rows inside the active count
    a_r4_pix_rows: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_o |-> (!refresh_o && (s_q.row < s_q.active)));
endmodule

// File: tb/sim_video_raster_timer.sv
`timescale 1ns/1ps
module sim_video_raster_timer;
    localparam int LINE  = 342;
    localparam int NL    = 30;
    localparam int PL    = 36;
    localparam int NVS   = 23;
    localparam int PVS   = 27;
    localparam int AB    = 16;
    localparam int AM    = 20;
    localparam int AT    = 24;
    localparam int LATCH = 61;
    localparam int IRQC  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pal_sel = 1'b0, ext_mode = 1'b0, text_mode = 1'b0, blank_disp = 1'b0, irq_clr = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [8:0] col_o;
    logic [5:0] row_o;
    logic sync_o, blank_o, burst_o, border_o, pixel_o, vsync_o, refresh_o, frame_irq_o;

    int n_chk = 0, n_bad = 0;
    int e_col = 0, e_row = 0, e_total = NL;
    bit done = 0;

    always #2 clk = ~clk;

    video_raster_timer #(
        .LINE_CYCLES(LINE), .NTSC_LINES(NL), .PAL_LINES(PL),
        .NTSC_VS(NVS), .PAL_VS(PVS), .ACT_BASE(AB), .ACT_MID(AM), .ACT_TALL(AT),
        .LATCH_COL(LATCH), .IRQ_COL(IRQC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .ext_mode(ext_mode),
        .mode_sel(mode_sel), .text_mode(text_mode), .blank_disp(blank_disp),
        .irq_clr(irq_clr), .col_o(col_o), .row_o(row_o), .sync_o(sync_o),
        .blank_o(blank_o), .burst_o(burst_o), .border_o(border_o),
        .pixel_o(pixel_o), .vsync_o(vsync_o), .refresh_o(refresh_o),
        .frame_irq_o(frame_irq_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at row %0d col %0d: got %0d expected %0d", tag, e_row, e_col, act, exp);
        end
    endtask

    // 0 border, 1 blank, 2 sync, 3 burst, 4 pixel, 7 not exactly one strobe
    function automatic int act_code();
        if ($countones({pixel_o, burst_o, sync_o, blank_o, border_o}) != 1) return 7;
        if (border_o) return 0;
        if (blank_o)  return 1;
        if (sync_o)   return 2;
        if (burst_o)  return 3;
        return 4;
    endfunction

    function automatic int exp_code(int c, bit txt, bit pix);
        int ps, pe;
        ps = txt ? 94 : 86;
        pe = txt ? 334 : 342;
        if (c < 15) return 0;
        if (c < 23) return 1;
        if (c < 49) return 2;
        if (c < 51) return 1;
        if (c < 65) return 3;
        if (c < 73) return 1;
        if (c < ps) return 0;
        if (c < pe && pix) return 4;
        return 0;
    endfunction

    task automatic adv1();
        @(posedge clk);
        if (e_row == 0 && e_col == LATCH) e_total = pal_sel ? PL : NL;
        if (e_col == LINE - 1) begin
            e_col = 0;
            e_row = (e_row == e_total - 1) ? 0 : e_row + 1;
        end else e_col++;
        @(negedge clk);
    endtask

    task automatic goto(int r, int c);
        for (int k = 0; k < 150000 && !(e_row == r && e_col == c); k++) adv1();
    endtask

    task automatic t_reset();
        chk("R1 reset col", int'(col_o), 0);
        chk("R1 reset row", int'(row_o), 0);
        chk("R10 reset irq", int'(frame_irq_o), 0);
        chk("R2 reset region", act_code(), 0);
    endtask

    task automatic t_layout();
        for (int c = 0; c < LINE; c++) begin
            chk(c < 86 ? "R2 layout" : "R3 std pixels", act_code(), exp_code(c, 0, 1));
            chk("R1 col count", int'(col_o), c);
            if (c < LINE - 1) adv1();
        end
        adv1();
        chk("R1 wrap col", int'(col_o), 0);
        chk("R1 wrap row", int'(row_o), 1);
    endtask

    task automatic t_text();
        goto(1, 100);
        text_mode = 1'b1;
        chk("R11 text not yet", act_code(), 4);
        goto(2, 0);
        for (int c = 0; c < LINE; c++) begin
            chk("R3 text layout", act_code(), exp_code(c, 1, 1));
            if (c < LINE - 1) adv1();
        end
        text_mode = 1'b0;
        adv1();
    endtask

    task automatic t_blank();
        goto(3, 10);
        blank_disp = 1'b1;
        goto(4, 100);
        chk("R11 blank refresh", int'(refresh_o), 1);
        chk("R4 blank border", act_code(), 0);
        blank_disp = 1'b0;
        goto(5, 100);
        chk("R11 unblank refresh", int'(refresh_o), 0);
        chk("R4 unblank pixel", act_code(), 4);
    endtask

    task automatic t_frame_ntsc();
        goto(AB - 1, 100);
        chk("R4 last active row", act_code(), 4);
        goto(AB, 100);
        chk("R11 first border row", int'(refresh_o), 1);
        chk("R4 first border row", act_code(), 0);
        goto(AB + 1, IRQC);
        chk("R10 irq before", int'(frame_irq_o), 0);
        adv1();
        chk("R10 irq set", int'(frame_irq_o), 1);
        goto(NVS - 1, 0);
        chk("R5 vsync before", int'(vsync_o), 0);
        goto(NVS, 0);
        chk("R5 vsync first", int'(vsync_o), 1);
        goto(NVS, 200);
        chk("R5 sync mid line", act_code(), 2);
        goto(NVS + 3, LINE - 1);
        chk("R5 vsync last", int'(vsync_o), 1);
        adv1();
        chk("R5 vsync end", int'(vsync_o), 0);
        chk("R5 vsync end region", act_code(), 0);
        goto(NL - 1, 100);
        chk("R11 last row refresh", int'(refresh_o), 0);
        chk("R4 last row border", act_code(), 0);
        chk("R10 irq held", int'(frame_irq_o), 1);
        goto(NL - 1, LINE - 1);
        adv1();
        chk("R6 ntsc wrap row", int'(row_o), 0);
        irq_clr = 1'b1;
        adv1();
        irq_clr = 1'b0;
        chk("R10 irq cleared", int'(frame_irq_o), 0);
    endtask

    task automatic t_ext_mid();
        ext_mode = 1'b1; pal_sel = 1'b1; mode_sel = 3'b011;
        goto(5, 0);
        mode_sel = 3'b110; pal_sel = 1'b0; ext_mode = 1'b0;
        goto(AM - 1, 100);
        chk("R7 mid pixel row", act_code(), 4);
        goto(AM, 100);
        chk("R9 mid border row", act_code(), 0);
        goto(AM + 1, IRQC + 1);
        chk("R10 ext irq", int'(frame_irq_o), 1);
        irq_clr = 1'b1; adv1(); irq_clr = 1'b0;
        goto((PL + AM) / 2 - 1, 0);
        chk("R8 mid before vsync", int'(vsync_o), 0);
        goto((PL + AM) / 2, 0);
        chk("R8 mid vsync", int'(vsync_o), 1);
        goto(NL - 1, LINE - 1);
        adv1();
        chk("R6 pal row beyond ntsc", int'(row_o), NL);
        pal_sel = 1'b1; ext_mode = 1'b1; mode_sel = 3'b111;
        goto(PL - 1, LINE - 1);
        adv1();
        chk("R6 pal wrap", int'(row_o), 0);
    endtask

    task automatic t_ext_tall();
        goto(0, 70);
        goto(AT - 1, 100);
        chk("R7 tall pixel row", act_code(), 4);
        goto(AT, 100);
        chk("R7 tall border row", act_code(), 0);
        goto(AT + 1, IRQC + 1);
        chk("R10 tall irq", int'(frame_irq_o), 1);
        irq_clr = 1'b1; adv1(); irq_clr = 1'b0;
        goto((PL + AT) / 2 - 1, 0);
        chk("R8 tall before vsync", int'(vsync_o), 0);
        goto((PL + AT) / 2, 0);
        chk("R8 tall vsync", int'(vsync_o), 1);
        ext_mode = 1'b0;
        goto(PL - 1, LINE - 1);
        adv1();
    endtask

    task automatic t_pal_std();
        goto(0, 70);
        goto(AB, 100);
        chk("R7 std border row", act_code(), 0);
        goto(PVS - 1, 0);
        chk("R6 pal before vsync", int'(vsync_o), 0);
        goto(PVS, 0);
        chk("R6 pal vsync", int'(vsync_o), 1);
        goto(PVS + 4, 0);
        chk("R5 pal vsync end", int'(vsync_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_text();
        t_blank();
        t_frame_ntsc();
        t_ext_mid();
        t_ext_tall();
        t_pal_std();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule